// File: doc/BRIEF.md
# Dual-mode timer with PWM output

A 32-bit up-counting timer peripheral driven from a simple single-cycle register bus. The counter advances on a tick chosen from one of three tick-strobe inputs, optionally slowed down by a power-of-two prescaler. When it passes its all-ones value it raises an overflow event. It then either restarts from a programmable load value or stops. A compare unit raises a match event when the counter steps onto a programmed value.

Overflow and match events are kept as sticky status bits. The status bits drive a maskable interrupt line and a separately maskable wake-up line. The same events can drive an output pin, either as a one-cycle pulse or as a toggle. The idle level of that pin is programmable and applies whenever the timer is stopped. A write to the trigger register forces the counter to the load value at any time.

Writes take effect on the rising clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. Register addresses are: 0 control, 1 counter, 2 load, 3 match, 4 trigger, 5 interrupt-enable set, 6 interrupt-enable clear, 7 status, 8 wake-up enable.

Top module: `pwm_timer32`

## Requirements
- R1: Control bit 0 (run) lets the counter advance by one per accepted tick. While run is 0 the counter holds its value.
- R2: On a step from all-ones with control bit 1 (autoreload) set, the counter takes the load register value and status bit 1 (overflow) is set.
- R3: On a step from all-ones with autoreload clear, the counter becomes 0, status bit 1 is set and the run bit clears itself, so the counter stays at 0.
- R4: With control bit 6 (compare enable) set, a step whose new counter value equals the match register sets status bit 0 (match). With compare enable clear, no match is recorded.
- R5: With control bit 5 (prescale enable) clear, the counter steps on every tick. With it set and control bits [4:2] holding n, it steps once every 2^(n+1) ticks counted from the start of the run.
- R6: `tick_sel` values 0, 1 and 2 choose `tick_src[0]`, `tick_src[1]` and `tick_src[2]`. Value 3 chooses no tick, and unselected sources have no effect.
- R7: Any write to the trigger register copies the load register into the counter, whatever the written data and whether or not the timer runs.
- R8: Control bits [11:10] choose the pin events. 0 gives none, 1 gives overflow, 2 gives overflow or match, and 3 gives none.
- R9: Control bit 12 picks the pin behaviour. At 0 (pulse), the pin is the inverse of the idle level for the one cycle after an event. At 1 (toggle), the pin inverts on each event and holds between events.
- R10: While run is 0, the pin follows control bit 7 (idle level) one cycle later.
- R11: A write to the set register ORs the data into the interrupt enables, and a write to the clear register removes the written bits. Both registers read back the enables. `irq` is high when any status bit and its enable are both 1.
- R12: Status bits are sticky. A status write clears the bits written as 1 and leaves the others, and the status register reads back the bits.
- R13: `wake` is high when any status bit and the same bit of the wake-up enable register are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_src | input | 3 | Tick strobes from three sources |
| tick_sel | input | 2 | Tick source choice |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |
| pwm_out | output | 1 | Timer output pin |

## Verification
A register write and a tick strobe both act on the following rising edge. Counter, status and pin values are therefore observable one edge after the stimulus. `irq`, `wake` and read data then follow with no further delay, being combinational from registers. The idle-level change of the pin needs one more edge, because run itself becomes 0 only at the write edge. The bench drives every input on a falling edge and samples shortly after the next falling edge. Each expected value is placed on the edge count above: one edge for counter, status and pulse checks, and two for idle-level checks.

// File: rtl/pwm_timer32_pkg.sv
package pwm_timer32_pkg;

  localparam int PRE_W    = 3;
  localparam int EV_W     = 3;
  localparam int EV_MATCH = 0;
  localparam int EV_OVF   = 1;
  localparam int EV_CAPT  = 2;
  localparam int CTRL_W   = 13;

  localparam int RA_CTRL    = 0;
  localparam int RA_COUNT   = 1;
  localparam int RA_LOAD    = 2;
  localparam int RA_MATCH   = 3;
  localparam int RA_TRIG    = 4;
  localparam int RA_IEN_SET = 5;
  localparam int RA_IEN_CLR = 6;
  localparam int RA_STATUS  = 7;
  localparam int RA_WAKE    = 8;

  typedef enum logic [1:0] {
    OM_NONE = 2'd0,
    OM_OVF  = 2'd1,
    OM_BOTH = 2'd2,
    OM_RSVD = 2'd3
  } out_mode_e;

  typedef struct packed {
    logic             toggle;     // 12
    out_mode_e        mode;       // 11:10
    logic [1:0]       spare;      // 9:8
    logic             idle_lvl;   // 7
    logic             cmp_en;     // 6
    logic             pre_en;     // 5
    logic [PRE_W-1:0] pre_val;    // 4:2
    logic             autoreload; // 1
    logic             run;        // 0
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
    ctrl_t c;
    c       = ctrl_t'(w);
    c.spare = '0;
    return c;
  endfunction

endpackage

// File: rtl/pwm_timer32_tick_gen.sv
module pwm_timer32_tick_gen
  import pwm_timer32_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] tick_src,
  input  logic [SEL_W-1:0]   tick_sel,
  input  logic               run,
  input  logic               pre_en,
  input  logic [PRE_W-1:0]   pre_val,
  output logic               step
);

  localparam int DIV_W = 1 << PRE_W;

  logic [NUM_SRC-1:0] src_hit;
  logic               tick;
  logic [DIV_W-1:0]   limit;
  logic               at_limit;
  logic [DIV_W-1:0]   pre_cnt_q;
  logic [DIV_W-1:0]   pre_cnt_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign src_hit[i] = tick_src[i] & (tick_sel == SEL_W'(i));
  end

  assign tick     = |src_hit;
  assign limit    = (DIV_W'(2) << pre_val) - DIV_W'(1);
  assign at_limit = (pre_cnt_q >= limit);
  assign step     = run & tick & (~pre_en | at_limit);

  always_comb begin
    pre_cnt_d = pre_cnt_q;
    if (!run) begin
      pre_cnt_d = '0;
    end else if (tick && pre_en) begin
      pre_cnt_d = at_limit ? '0 : pre_cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt_q <= '0;
    else        pre_cnt_q <= pre_cnt_d;
  end

  // R5: a prescaled step only happens once the divider has counted up
  assert_pre_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pre_en) |-> (pre_cnt_q != '0 || limit == '0))
    else $error("prescaled step without divider count");

endmodule

// File: rtl/pwm_timer32_count_core.sv
module pwm_timer32_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic             autoreload,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             reload_req,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_ev,
  output logic             match_ev,
  output logic             halt_req
);

  logic             at_top;
  logic [CNT_W-1:0] step_val;
  logic [CNT_W-1:0] count_d;

  assign at_top   = (count_q == '1);
  assign step_val = at_top ? (autoreload ? load_val : '0) : count_q + CNT_W'(1);
  assign ovf_ev   = step & at_top;
  assign match_ev = step & cmp_en & (step_val == match_val);
  assign halt_req = ovf_ev & ~autoreload;

  always_comb begin
    count_d = count_q;
    if (cnt_wr)          count_d = cnt_wdata;
    else if (reload_req) count_d = load_val;
    else if (step)       count_d = step_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assert_halt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr && !reload_req) |=> $stable(count_q))
    else $error("counter moved while halted");

  assert_autoreload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev && autoreload && !cnt_wr && !reload_req) |=> (count_q == $past(load_val)))
    else $error("no reload after overflow");

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev && !autoreload && !cnt_wr && !reload_req) |=> (count_q == '0))
    else $error("counter not zero after plain overflow");

  assert_trigger_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_req && !cnt_wr) |=> (count_q == $past(load_val)))
    else $error("trigger did not load counter");

endmodule

// File: rtl/pwm_timer32_out_gen.sv
module pwm_timer32_out_gen
  import pwm_timer32_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      toggle,
  input  logic      idle_lvl,
  input  out_mode_e mode,
  input  logic      ovf_ev,
  input  logic      match_ev,
  output logic      pin_q
);

  logic trig_ev;
  logic pin_d;

  always_comb begin
    unique case (mode)
      OM_OVF:  trig_ev = ovf_ev;
      OM_BOTH: trig_ev = ovf_ev | match_ev;
      default: trig_ev = 1'b0;
    endcase
  end

  always_comb begin
    if (!run)        pin_d = idle_lvl;
    else if (toggle) pin_d = pin_q ^ trig_ev;
    else             pin_d = idle_lvl ^ trig_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assert_idle_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pin_q == $past(idle_lvl)))
    else $error("pin not at idle level while stopped");

  assert_toggle_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && toggle && (ovf_ev || match_ev) && mode == OM_BOTH) |=> (pin_q != $past(pin_q)))
    else $error("toggle pin did not flip");

  assert_no_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && toggle && (mode == OM_NONE || mode == OM_RSVD)) |=> $stable(pin_q))
    else $error("pin moved with events disabled");

endmodule

// File: rtl/pwm_timer32_irq_ctrl.sv
module pwm_timer32_irq_ctrl
  import pwm_timer32_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev,
  input  logic            ien_set_wr,
  input  logic            ien_clr_wr,
  input  logic            wen_wr,
  input  logic            sts_wr,
  input  logic [EV_W-1:0] wdata,
  output logic [EV_W-1:0] status_q,
  output logic [EV_W-1:0] ien_q,
  output logic [EV_W-1:0] wen_q,
  output logic            irq,
  output logic            wake
);

  logic [EV_W-1:0] status_d;
  logic [EV_W-1:0] ien_d;
  logic [EV_W-1:0] wen_d;
  logic [EV_W-1:0] clr_mask;

  assign clr_mask = sts_wr ? wdata : '0;

  always_comb begin
    status_d = (status_q & ~clr_mask) | ev;
    ien_d    = ien_q;
    if (ien_set_wr) ien_d = ien_d | wdata;
    if (ien_clr_wr) ien_d = ien_d & ~wdata;
    wen_d    = wen_wr ? wdata : wen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ien_q    <= '0;
      wen_q    <= '0;
    end else begin
      status_q <= status_d;
      ien_q    <= ien_d;
      wen_q    <= wen_d;
    end
  end

  assign irq  = |(status_q & ien_q);
  assign wake = |(status_q & wen_q);

  assert_w1c_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && ev == '0) |=> ((status_q & $past(wdata)) == '0))
    else $error("status bit survived clear");

  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_wr) |=> ((status_q & $past(status_q)) == $past(status_q)))
    else $error("status bit lost without clear");

  assert_ien_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_clr_wr && !ien_set_wr) |=> ((ien_q & $past(wdata)) == '0))
    else $error("enable survived clear write");

endmodule

// File: rtl/pwm_timer32.sv
module pwm_timer32
  import pwm_timer32_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] tick_src,
  input  logic [SEL_W-1:0]   tick_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq,
  output logic               wake,
  output logic               pwm_out
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // write decode
  logic wr_ctrl, wr_count, wr_load, wr_match, wr_trig;
  logic wr_iset, wr_iclr, wr_sts, wr_wen;

  assign wr_ctrl  = bus_wr & (bus_addr == ADDR_W'(RA_CTRL));
  assign wr_count = bus_wr & (bus_addr == ADDR_W'(RA_COUNT));
  assign wr_load  = bus_wr & (bus_addr == ADDR_W'(RA_LOAD));
  assign wr_match = bus_wr & (bus_addr == ADDR_W'(RA_MATCH));
  assign wr_trig  = bus_wr & (bus_addr == ADDR_W'(RA_TRIG));
  assign wr_iset  = bus_wr & (bus_addr == ADDR_W'(RA_IEN_SET));
  assign wr_iclr  = bus_wr & (bus_addr == ADDR_W'(RA_IEN_CLR));
  assign wr_sts   = bus_wr & (bus_addr == ADDR_W'(RA_STATUS));
  assign wr_wen   = bus_wr & (bus_addr == ADDR_W'(RA_WAKE));

  // configuration registers
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] load_q, load_d;
  logic [CNT_W-1:0] match_q, match_d;
  logic             halt_req;

  always_comb begin
    ctrl_d  = ctrl_q;
    load_d  = load_q;
    match_d = match_q;
    if (halt_req) ctrl_d.run = 1'b0;
    if (wr_ctrl)  ctrl_d = decode_ctrl(bus_wdata[CTRL_W-1:0]);
    if (wr_load)  load_d = bus_wdata[CNT_W-1:0];
    if (wr_match) match_d = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      load_q  <= load_d;
      match_q <= match_d;
    end
  end

  // datapath
  logic             step;
  logic [CNT_W-1:0] count_q;
  logic             ovf_ev, match_ev;
  logic [EV_W-1:0]  ev_vec;
  logic [EV_W-1:0]  status_q, ien_q, wen_q;

  pwm_timer32_tick_gen #(
    .NUM_SRC (NUM_SRC),
    .SEL_W   (SEL_W)
  ) u_tick (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick_src (tick_src),
    .tick_sel (tick_sel),
    .run      (ctrl_q.run),
    .pre_en   (ctrl_q.pre_en),
    .pre_val  (ctrl_q.pre_val),
    .step     (step)
  );

  pwm_timer32_count_core #(
    .CNT_W (CNT_W)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run        (ctrl_q.run),
    .step       (step),
    .autoreload (ctrl_q.autoreload),
    .cmp_en     (ctrl_q.cmp_en),
    .load_val   (load_q),
    .match_val  (match_q),
    .cnt_wr     (wr_count),
    .cnt_wdata  (bus_wdata[CNT_W-1:0]),
    .reload_req (wr_trig),
    .count_q    (count_q),
    .ovf_ev     (ovf_ev),
    .match_ev   (match_ev),
    .halt_req   (halt_req)
  );

  pwm_timer32_out_gen u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (ctrl_q.run),
    .toggle   (ctrl_q.toggle),
    .idle_lvl (ctrl_q.idle_lvl),
    .mode     (ctrl_q.mode),
    .ovf_ev   (ovf_ev),
    .match_ev (match_ev),
    .pin_q    (pwm_out)
  );

  always_comb begin
    ev_vec           = '0;
    ev_vec[EV_MATCH] = match_ev;
    ev_vec[EV_OVF]   = ovf_ev;
    ev_vec[EV_CAPT]  = 1'b0;
  end

  pwm_timer32_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ev         (ev_vec),
    .ien_set_wr (wr_iset),
    .ien_clr_wr (wr_iclr),
    .wen_wr     (wr_wen),
    .sts_wr     (wr_sts),
    .wdata      (bus_wdata[EV_W-1:0]),
    .status_q   (status_q),
    .ien_q      (ien_q),
    .wen_q      (wen_q),
    .irq        (irq),
    .wake       (wake)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(RA_CTRL))         bus_rdata = DATA_W'(ctrl_q);
    else if (bus_addr == ADDR_W'(RA_COUNT))   bus_rdata = DATA_W'(count_q);
    else if (bus_addr == ADDR_W'(RA_LOAD))    bus_rdata = DATA_W'(load_q);
    else if (bus_addr == ADDR_W'(RA_MATCH))   bus_rdata = DATA_W'(match_q);
    else if (bus_addr == ADDR_W'(RA_IEN_SET) ||
             bus_addr == ADDR_W'(RA_IEN_CLR)) bus_rdata = DATA_W'(ien_q);
    else if (bus_addr == ADDR_W'(RA_STATUS))  bus_rdata = DATA_W'(status_q);
    else if (bus_addr == ADDR_W'(RA_WAKE))    bus_rdata = DATA_W'(wen_q);
  end

  assert_self_stop_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ovf_ev && !ctrl_q.autoreload && !wr_ctrl) |=> !ctrl_q.run)
    else $error("run bit stayed set after plain overflow");

  assert_match_flag_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step && ctrl_q.cmp_en && !wr_count && !wr_trig) |=>
      ((count_q != match_q) || status_q[EV_MATCH] || $past(wr_match)))
    else $error("match reached without status");

endmodule

// File: tb/tb_pwm_timer32.sv
module tb_pwm_timer32;
  localparam int CLK_PERIOD = 10;
  localparam int A_CTRL = 0, A_COUNT = 1, A_LOAD = 2, A_MATCH = 3, A_TRIG = 4;
  localparam int A_ISET = 5, A_ICLR = 6, A_STS = 7, A_WAKE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  tick_src = '0;
  logic [1:0]  tick_sel = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wake, pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_timer32 dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_src  (tick_src),
    .tick_sel  (tick_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .wake      (wake),
    .pwm_out   (pwm_out)
  );

  function automatic logic [31:0] mkc(input bit run, input bit ar, input bit pe,
                                      input int pv, input bit ce, input bit idle,
                                      input int mode, input bit tog);
    return 32'(run) | (32'(ar) << 1) | (32'(pv & 7) << 2) | (32'(pe) << 5) |
           (32'(ce) << 6) | (32'(idle) << 7) | (32'(mode & 3) << 10) | (32'(tog) << 12);
  endfunction

  function automatic logic [31:0] exp_steps(input logic [31:0] init, input int nt,
                                            input bit pe, input int pv);
    int div;
    div = pe ? (2 << pv) : 1;
    return init + 32'(nt / div);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr  = a[3:0];
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
    #1;
  endtask

  task automatic chk_rd(input string tag, input int a, input logic [31:0] exp);
    bus_addr = a[3:0];
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic ticks(input logic [2:0] m, input int k);
    if (k > 0) begin
      tick_src = m;
      repeat (k) @(negedge clk);
      tick_src = '0;
      #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] init;
    logic [31:0] seed_v;
    int pe, pv, nt;
    seed_v = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // reset state
    chk_rd("R1 reset count", A_COUNT, 32'h0);
    chk_rd("R1 reset ctrl", A_CTRL, 32'h0);
    chk("R10 reset pin", 32'(pwm_out), 32'h0);
    chk("R11 reset irq", 32'(irq), 32'h0);
    chk("R13 reset wake", 32'(wake), 32'h0);

    // R1 run and halt
    wr(A_COUNT, 32'd100);
    wr(A_CTRL, mkc(1, 0, 0, 0, 0, 0, 0, 0));
    ticks(3'b001, 7);
    chk_rd("R1 running", A_COUNT, 32'd107);
    wr(A_CTRL, mkc(0, 0, 0, 0, 0, 0, 0, 0));
    ticks(3'b001, 5);
    chk_rd("R1 halted", A_COUNT, 32'd107);

    // R6 tick source choice
    wr(A_CTRL, mkc(1, 0, 0, 0, 0, 0, 0, 0));
    tick_sel = 2'd1;
    ticks(3'b101, 4);
    chk_rd("R6 unselected sources", A_COUNT, 32'd107);
    ticks(3'b010, 4);
    chk_rd("R6 source 1", A_COUNT, 32'd111);
    tick_sel = 2'd2;
    ticks(3'b100, 3);
    chk_rd("R6 source 2", A_COUNT, 32'd114);
    tick_sel = 2'd3;
    ticks(3'b111, 6);
    chk_rd("R6 no source", A_COUNT, 32'd114);
    tick_sel = 2'd0;

    // R5 prescaler, directed
    wr(A_CTRL, 32'h0);
    wr(A_COUNT, 32'h0);
    wr(A_CTRL, mkc(1, 0, 1, 1, 0, 0, 0, 0));
    ticks(3'b001, 3);
    chk_rd("R5 div4 before", A_COUNT, 32'd0);
    ticks(3'b001, 5);
    chk_rd("R5 div4 after 8", A_COUNT, 32'd2);
    wr(A_CTRL, 32'h0);
    wr(A_COUNT, 32'h0);
    wr(A_CTRL, mkc(1, 0, 1, 7, 0, 0, 0, 0));
    ticks(3'b001, 255);
    chk_rd("R5 div256 before", A_COUNT, 32'd0);
    ticks(3'b001, 1);
    chk_rd("R5 div256 at", A_COUNT, 32'd1);

    // R5 prescaler, random
    for (int it = 0; it < 16; it++) begin
      init = $urandom & 32'hFFFF;
      pe   = $urandom_range(0, 1);
      pv   = $urandom_range(0, 3);
      nt   = $urandom_range(0, 40);
      wr(A_CTRL, 32'h0);
      wr(A_COUNT, init);
      wr(A_CTRL, mkc(1, 0, pe[0], pv, 0, 0, 0, 0));
      ticks(3'b001, nt);
      chk_rd("R5 random", A_COUNT, exp_steps(init, nt, pe[0], pv));
    end

    // R4 compare
    wr(A_CTRL, mkc(1, 0, 0, 0, 1, 0, 0, 0));
    wr(A_STS, 32'h7);
    wr(A_MATCH, 32'h10);
    wr(A_COUNT, 32'h0E);
    ticks(3'b001, 1);
    chk_rd("R4 before match", A_STS, 32'h0);
    ticks(3'b001, 1);
    chk_rd("R4 match status", A_STS, 32'h1);
    wr(A_STS, 32'h1);
    chk_rd("R12 match cleared", A_STS, 32'h0);
    wr(A_CTRL, mkc(1, 0, 0, 0, 0, 0, 0, 0));
    wr(A_COUNT, 32'h0E);
    ticks(3'b001, 3);
    chk_rd("R4 compare off", A_STS, 32'h0);

    // R2 autoreload
    wr(A_LOAD, 32'h100);
    wr(A_COUNT, 32'hFFFF_FFFE);
    wr(A_CTRL, mkc(1, 1, 0, 0, 0, 0, 0, 0));
    ticks(3'b001, 1);
    chk_rd("R2 at top", A_COUNT, 32'hFFFF_FFFF);
    ticks(3'b001, 1);
    chk_rd("R2 reloaded", A_COUNT, 32'h100);
    chk_rd("R2 ovf status", A_STS, 32'h2);

    // R7 trigger
    wr(A_COUNT, 32'd5);
    wr(A_TRIG, 32'hDEAD_BEEF);
    chk_rd("R7 trigger running", A_COUNT, 32'h100);
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, 32'h77);
    wr(A_TRIG, 32'h0);
    chk_rd("R7 trigger stopped", A_COUNT, 32'h77);

    // R3 stop after overflow
    wr(A_STS, 32'h7);
    wr(A_COUNT, 32'hFFFF_FFFF);
    wr(A_CTRL, mkc(1, 0, 0, 0, 0, 0, 0, 0));
    ticks(3'b001, 1);
    chk_rd("R3 wrapped", A_COUNT, 32'h0);
    chk_rd("R3 run cleared", A_CTRL, 32'h0);
    ticks(3'b001, 3);
    chk_rd("R3 stays", A_COUNT, 32'h0);
    chk_rd("R3 ovf status", A_STS, 32'h2);

    // R12 write-one-to-clear
    wr(A_CTRL, mkc(1, 0, 0, 0, 1, 0, 0, 0));
    wr(A_MATCH, 32'h3);
    wr(A_COUNT, 32'h2);
    ticks(3'b001, 1);
    chk_rd("R12 both set", A_STS, 32'h3);
    wr(A_STS, 32'h0);
    chk_rd("R12 zero write", A_STS, 32'h3);
    wr(A_STS, 32'h1);
    chk_rd("R12 partial clear", A_STS, 32'h2);

    // R11 interrupt enables
    wr(A_ISET, 32'h1);
    chk("R11 masked", 32'(irq), 32'h0);
    chk_rd("R11 read set", A_ISET, 32'h1);
    wr(A_ISET, 32'h2);
    chk("R11 enabled", 32'(irq), 32'h1);
    chk_rd("R11 read or", A_ICLR, 32'h3);
    wr(A_ICLR, 32'h2);
    chk("R11 cleared", 32'(irq), 32'h0);
    chk_rd("R11 read clr", A_ISET, 32'h1);

    // R13 wake
    chk("R13 none", 32'(wake), 32'h0);
    wr(A_WAKE, 32'h2);
    chk("R13 enabled", 32'(wake), 32'h1);
    chk_rd("R13 read", A_WAKE, 32'h2);
    wr(A_WAKE, 32'h1);
    chk("R13 other bit", 32'(wake), 32'h0);
    wr(A_STS, 32'h7);

    // R8/R9 pulse on overflow
    wr(A_LOAD, 32'h20);
    wr(A_COUNT, 32'hFFFF_FFFF);
    wr(A_CTRL, mkc(1, 1, 0, 0, 1, 0, 1, 0));
    ticks(3'b001, 1);
    chk("R9 pulse high", 32'(pwm_out), 32'h1);
    @(negedge clk); #1;
    chk("R9 pulse ends", 32'(pwm_out), 32'h0);
    wr(A_MATCH, 32'h22);
    ticks(3'b001, 2);
    chk("R8 overflow mode ignores match", 32'(pwm_out), 32'h0);
    chk_rd("R8 count", A_COUNT, 32'h22);

    // R9 toggle on overflow or match
    wr(A_CTRL, mkc(1, 1, 0, 0, 1, 0, 2, 1));
    wr(A_MATCH, 32'h24);
    ticks(3'b001, 1);
    chk("R9 toggle idle", 32'(pwm_out), 32'h0);
    ticks(3'b001, 1);
    chk("R9 toggle on match", 32'(pwm_out), 32'h1);
    ticks(3'b001, 3);
    chk("R9 toggle holds", 32'(pwm_out), 32'h1);
    wr(A_COUNT, 32'hFFFF_FFFF);
    ticks(3'b001, 1);
    chk("R9 toggle on overflow", 32'(pwm_out), 32'h0);

    // R8 reserved mode
    wr(A_CTRL, mkc(1, 1, 0, 0, 1, 0, 3, 1));
    wr(A_MATCH, 32'h21);
    ticks(3'b001, 1);
    chk("R8 reserved mode", 32'(pwm_out), 32'h0);
    wr(A_CTRL, mkc(1, 1, 0, 0, 1, 0, 0, 1));
    wr(A_MATCH, 32'h22);
    ticks(3'b001, 1);
    chk("R8 mode none", 32'(pwm_out), 32'h0);

    // R10 idle level
    wr(A_CTRL, mkc(0, 0, 0, 0, 0, 1, 0, 0));
    @(negedge clk); #1;
    chk("R10 idle high", 32'(pwm_out), 32'h1);
    ticks(3'b001, 2);
    chk("R10 idle holds", 32'(pwm_out), 32'h1);
    wr(A_CTRL, mkc(0, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk); #1;
    chk("R10 idle low", 32'(pwm_out), 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule